// File: doc/BRIEF.md
# Partitioned 8x16 Rounding Multiplier

This block multiplies unsigned 8-bit pixel values by signed 16-bit coefficients in parallel lanes and returns the middle sixteen bits of each product, rounded half up. A 3-bit mode input picks how the lanes are fed and where their results go. Four lanes can each take their own coefficient or share one half of the second operand. The multiplicand can come from packed bytes or from the upper or lower byte of each 16-bit field. Two-lane wide forms place each result inside a 32-bit slot.

Operands, mode and a valid flag enter on one clock edge. The result and its valid flag leave two cycles later. The first pipeline stage registers the raw signed products. The second registers the rounded and placed result word. A new operation can be issued on every cycle.

Top module: `part_mul8x16`

## Requirements
- R1: For every lane, the lane result is the 25-bit signed product of a zero-extended 8-bit pixel and a signed 16-bit coefficient. The result takes product bits [23:8] and adds one when product bit 7 is set, wrapping modulo 2^16.
- R2: Mode 0 (per-lane): pixel k is in_a[8k+7:8k] and coefficient k is in_b[16k+15:16k], for k = 0..3. Result k lands in out_data[16k+15:16k].
- R3: Modes 1 and 2 (shared coefficient): pixel k is in_a[8k+7:8k]. All four lanes use in_b[31:16] in mode 1 and in_b[15:0] in mode 2. Result k lands in out_data[16k+15:16k].
- R4: Modes 3 and 4 (byte select): pixel k is in_a[16k+15:16k+8] in mode 3 and in_a[16k+7:16k] in mode 4. Coefficient k is in_b[16k+15:16k]. Result k lands in out_data[16k+15:16k].
- R5: Modes 5 and 6 (wide): only lanes 0 and 1 are used. Pixel k is in_a[16k+15:16k+8] in mode 5 and in_a[16k+7:16k] in mode 6, and coefficient k is in_b[16k+15:16k]. Result k lands in out_data[32k+22:32k+7], and every other output bit is zero.
- R6: Mode 7 is unused and gives an all-zero result.
- R7: out_data and out_valid show the operation presented exactly two clock edges earlier. A result is produced on every cycle, and out_valid follows in_valid.
- R8: While rst_n is low, out_valid and out_data are zero.
- R9: An all-zero in_a gives an all-zero result in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_mode | input | 3 | Variant select, codes 0..7 |
| in_a | input | 64 | Pixel operand |
| in_b | input | 64 | Coefficient operand |
| out_valid | output | 1 | Result valid, two cycles after in_valid |
| out_data | output | 64 | Packed lane results |

## Verification
The bench pairs a 0xFF pixel with the most negative coefficient 0x8000. A design that treats the pixel as signed, or that drops the product's sign bit, gives the wrong upper bits there. It also feeds a pixel of 1 with a coefficient of 0x0080, where only the rounding bit makes the result nonzero. A design that truncates would return zero. Wide-mode operands carry nonzero values in the unused upper lanes. Any leakage from those lanes, or a wrong 7-bit slot offset, corrupts bits that must stay zero. Random valid patterns show whether the flag drifts from the data by a cycle.

// File: rtl/part_mul_pkg.sv
package part_mul_pkg;

  typedef enum logic [2:0] {
    MODE_LANE    = 3'd0,
    MODE_SHR_HI  = 3'd1,
    MODE_SHR_LO  = 3'd2,
    MODE_BYTE_HI = 3'd3,
    MODE_BYTE_LO = 3'd4,
    MODE_WIDE_HI = 3'd5,
    MODE_WIDE_LO = 3'd6,
    MODE_NONE    = 3'd7
  } mul_mode_e;

  function automatic logic mode_is_wide(input mul_mode_e m);
    return (m == MODE_WIDE_HI) || (m == MODE_WIDE_LO);
  endfunction

endpackage

// File: rtl/pmul_select.sv
module pmul_select
  import part_mul_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  localparam int DATA_W = LANES * COEF_W
) (
  input  mul_mode_e                      mode,
  input  logic [DATA_W-1:0]              opa,
  input  logic [DATA_W-1:0]              opb,
  output logic [LANES-1:0][PIX_W-1:0]    pix,
  output logic [LANES-1:0][COEF_W-1:0]   coef
);

  localparam int WIDE_LANES = LANES / 2;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PIX_W-1:0]  pix_packed, pix_upper, pix_lower;
    logic [COEF_W-1:0] coef_own;
    logic              wide_off;

    assign pix_packed = opa[k*PIX_W +: PIX_W];
    assign pix_upper  = opa[k*COEF_W + PIX_W +: PIX_W];
    assign pix_lower  = opa[k*COEF_W +: PIX_W];
    assign coef_own   = opb[k*COEF_W +: COEF_W];
    assign wide_off   = (k >= WIDE_LANES);

    always_comb begin
      pix[k]  = '0;
      coef[k] = coef_own;
      unique case (mode)
        MODE_LANE:    pix[k] = pix_packed;
        MODE_SHR_HI: begin
          pix[k]  = pix_packed;
          coef[k] = opb[COEF_W +: COEF_W];
        end
        MODE_SHR_LO: begin
          pix[k]  = pix_packed;
          coef[k] = opb[0 +: COEF_W];
        end
        MODE_BYTE_HI: pix[k] = pix_upper;
        MODE_BYTE_LO: pix[k] = pix_lower;
        MODE_WIDE_HI: pix[k] = wide_off ? '0 : pix_upper;
        MODE_WIDE_LO: pix[k] = wide_off ? '0 : pix_lower;
        default:      pix[k] = '0;
      endcase
    end
  end

endmodule

// File: rtl/pmul_lane.sv
module pmul_lane #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  localparam int PROD_W = PIX_W + COEF_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PIX_W-1:0]         pix,
  input  logic [COEF_W-1:0]        coef,
  output logic signed [PROD_W-1:0] prod_q
);

  function automatic logic signed [PROD_W-1:0] mul_us(
    input logic [PIX_W-1:0] p, input logic [COEF_W-1:0] c);
    logic signed [PROD_W-1:0] pe, ce;
    pe = {{(PROD_W-PIX_W){1'b0}}, p};
    ce = {{(PROD_W-COEF_W){c[COEF_W-1]}}, c};
    return pe * ce;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) prod_q <= '0;
    else        prod_q <= mul_us(pix, coef);
  end

endmodule

// File: rtl/pmul_pack.sv
module pmul_pack
  import part_mul_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  localparam int PROD_W = PIX_W + COEF_W + 1,
  localparam int DATA_W = LANES * COEF_W
) (
  input  mul_mode_e                    mode,
  input  logic [LANES-1:0][PROD_W-1:0] prod,
  output logic [DATA_W-1:0]            data
);

  localparam int SLOT_W     = 2 * COEF_W;
  localparam int SHIFT      = PIX_W - 1;
  localparam int PAD_W      = SLOT_W - COEF_W - SHIFT;
  localparam int WIDE_LANES = LANES / 2;

  function automatic logic [COEF_W-1:0] mid_round(input logic [PROD_W-1:0] p);
    return p[PIX_W +: COEF_W] + {{(COEF_W-1){1'b0}}, p[PIX_W-1]};
  endfunction

  logic [LANES-1:0][COEF_W-1:0]     rounded;
  logic [WIDE_LANES-1:0][SLOT_W-1:0] wide_slot;
  logic [DATA_W-1:0]                 narrow_word, wide_word;

  for (genvar k = 0; k < LANES; k++) begin : g_rnd
    assign rounded[k] = mid_round(prod[k]);
  end

  for (genvar k = 0; k < WIDE_LANES; k++) begin : g_wide
    assign wide_slot[k] = {{PAD_W{1'b0}}, rounded[k], {SHIFT{1'b0}}};
  end

  assign narrow_word = rounded;
  assign wide_word   = wide_slot;
  assign data        = mode_is_wide(mode) ? wide_word : narrow_word;

endmodule

// File: rtl/part_mul8x16.sv
module part_mul8x16
  import part_mul_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  localparam int DATA_W = LANES * COEF_W,
  localparam int PROD_W = PIX_W + COEF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_mode,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  mul_mode_e                     mode_in, s1_mode;
  logic [LANES-1:0][PIX_W-1:0]   pix;
  logic [LANES-1:0][COEF_W-1:0]  coef;
  logic [LANES-1:0][PROD_W-1:0]  s1_prod;
  logic [DATA_W-1:0]             packed_res;
  logic                          s1_valid;

  assign mode_in = mul_mode_e'(in_mode);

  pmul_select #(.LANES(LANES), .PIX_W(PIX_W), .COEF_W(COEF_W)) u_sel (
    .mode(mode_in), .opa(in_a), .opb(in_b), .pix(pix), .coef(coef)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_mul
    logic signed [PROD_W-1:0] p_q;
    pmul_lane #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .pix(pix[k]), .coef(coef[k]), .prod_q(p_q)
    );
    assign s1_prod[k] = p_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_mode  <= MODE_LANE;
    end else begin
      s1_valid <= in_valid;
      s1_mode  <= mode_in;
    end
  end

  pmul_pack #(.LANES(LANES), .PIX_W(PIX_W), .COEF_W(COEF_W)) u_pack (
    .mode(s1_mode), .prod(s1_prod), .data(packed_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      out_data  <= packed_res;
    end
  end

endmodule

// File: rtl/pmul_checker.sv
module pmul_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        in_mode,
  input logic [DATA_W-1:0] in_a,
  input logic              s1_valid,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);

  localparam logic [63:0] WIDE_HOLES = ~64'h007F_FF80_007F_FF80;

  assert_stage1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);

  assert_stage2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);

  assert_no_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  assert_wide_holes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode == 3'd5 || in_mode == 3'd6) |-> ##2 ((out_data & WIDE_HOLES[DATA_W-1:0]) == '0));

  assert_unused_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode == 3'd7) |-> ##2 (out_data == '0));

  assert_zero_pixel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_a == '0) |-> ##2 (out_data == '0));

endmodule

bind part_mul8x16 pmul_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
  .in_a(in_a), .s1_valid(s1_valid), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_part_mul8x16.sv
module sim_part_mul8x16;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_mode = 3'd0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        exp_v[$];
  logic [63:0] exp_d[$];
  int          exp_m[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  part_mul8x16 u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] model(int mode, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    int n = (mode == 5 || mode == 6) ? 2 : 4;
    if (mode == 7) return '0;
    for (int k = 0; k < n; k++) begin
      int pix, cf, prod, mid;
      case (mode)
        0, 1, 2: pix = int'(a[8*k +: 8]);
        3, 5:    pix = int'(a[16*k+8 +: 8]);
        default: pix = int'(a[16*k +: 8]);
      endcase
      case (mode)
        1:       cf = $signed(b[31:16]);
        2:       cf = $signed(b[15:0]);
        default: cf = $signed(b[16*k +: 16]);
      endcase
      prod = pix * cf;
      mid  = ((prod >>> 8) + ((prod >>> 7) & 1)) & 32'hFFFF;
      if (n == 2) r = r | (64'(mid) << (32*k + 7));
      else        r = r | (64'(mid) << (16*k));
    end
    return r;
  endfunction

  function automatic string tag_of(int mode);
    case (mode)
      0:       return "R2";
      1, 2:    return "R3";
      3, 4:    return "R4";
      5, 6:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check_out(logic ev, logic [63:0] ed, int em, logic [63:0] ea);
    checks++;
    if (out_valid !== ev) begin
      errors++;
      $display("FAIL R7 valid: actual %0b expected %0b", out_valid, ev);
    end
    checks++;
    if (out_data !== ed) begin
      errors++;
      if (ea == '0)
        $display("FAIL R9 mode %0d: actual %h expected %h", em, out_data, ed);
      else
        $display("FAIL %s/R1 mode %0d: actual %h expected %h", tag_of(em), em, out_data, ed);
    end
  endtask

  logic [63:0] exp_a[$];

  task automatic step(logic v, int mode, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    check_out(exp_v.pop_front(), exp_d.pop_front(), exp_m.pop_front(), exp_a.pop_front());
    in_valid = v;
    in_mode  = 3'(mode);
    in_a     = a;
    in_b     = b;
    exp_v.push_back(v);
    exp_d.push_back(model(mode, a, b));
    exp_m.push_back(mode);
    exp_a.push_back(a);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      errors++;
      $display("FAIL R8 reset: actual %0b/%h expected 0/0", out_valid, out_data);
    end
    repeat (2) begin
      exp_v.push_back(1'b0);
      exp_d.push_back('0);
      exp_m.push_back(0);
      exp_a.push_back('0);
    end
    rst_n = 1'b1;

    for (int m = 0; m < 8; m++) begin
      // R1: 0xFF pixel against most negative coefficient
      step(1'b1, m, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_8000_8000_8000);
      // R1: rounding bit alone makes the result 1
      step(1'b1, m, 64'h0101_0101_0101_0101, 64'h0080_0080_0080_0080);
      // R1: largest positive coefficient
      step(1'b1, m, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF);
      // R1: negative one coefficient
      step(1'b1, m, 64'h8080_8080_8080_8080, 64'hFFFF_FFFF_FFFF_FFFF);
      // R9: zero pixels
      step(1'b1, m, 64'h0, rnd64());
      // R3: distinct halves to expose the wrong shared half
      step(1'b1, m, 64'h1234_5678_9ABC_DEF0, 64'h1111_2222_C000_0101);
      for (int i = 0; i < 40; i++)
        step(1'($urandom_range(0, 1)), m, rnd64(), rnd64());
    end
    // R7: back-to-back mode changes
    for (int i = 0; i < 60; i++)
      step(1'b1, $urandom_range(0, 7), rnd64(), rnd64());
    step(1'b0, 0, '0, '0);
    step(1'b0, 0, '0, '0);
    step(1'b0, 0, '0, '0);
    finish_run();
  end

endmodule